// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache with Age-Based Replacement

This block sits between a processor read port and a slower word-wide memory. It has 256 sets of four ways, and each way holds a valid flag, a tag and one data word. A request carries a word address. The low eight bits select a set, and the remaining upper bits form the tag. The four stored tags of that set are compared at the same time. When a valid way matches, its word is returned through a one-hot selector in the same cycle as the request.

On a miss, the processor sees a stall, and the block issues a read to memory for the missing word. The block waits for memory to signal ready, then writes the returned word into the chosen way. The processor keeps its request and address unchanged throughout the stall, so the cycle after the fill it hits and receives the word.

The choice of way follows two rules in order. An empty way is used first, and among empty ways the lowest-numbered one is taken. When the set is full, the least recently used way is evicted. Each set keeps a 2-bit age for every way. The ages are refreshed by every hit and every fill.

Top module: `sa_lru_cache`

## Requirements
- R1: After reset every way is invalid: with no request, cpu_stall, cpu_rvalid and mem_req are all low, and the first request to any address misses.
- R2: cpu_addr is a word address; bits [7:0] select the set and bits [31:8] are the tag, so addresses equal in bits [7:0] compete for the same four ways.
- R3: A request that finds a valid way with a matching tag raises cpu_rvalid in that same cycle with that way's word on cpu_rdata, keeps cpu_stall low and issues no memory read.
- R4: A request that misses raises cpu_stall in its first cycle; from the next cycle mem_req is high with mem_addr equal to the requested address.
- R5: In the cycle where mem_req and mem_ready are both high, mem_rdata is stored; in the next cycle the held request hits and returns exactly that word.
- R6: While a set still has an invalid way, a miss in that set evicts no valid line: all previously filled lines of the set still hit.
- R7: A miss in a full set replaces the line whose most recent hit or fill is the oldest of the four; a later request to it misses again.
- R8: A hit refreshes the line's recency, so a line hit more recently than another valid line of its set is not evicted before that other line.
- R9: Hits, fills and evictions in one set leave the contents and recency of every other set unchanged.
- R10: For any request, at most one way of the selected set matches.
- R11: While a fill is outstanding, mem_req and cpu_stall stay high, cpu_rvalid stays low, and mem_addr does not change until mem_ready is seen.
- R12: mem_ready asserted while mem_req is low has no effect on the cache contents or outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Read request, held until cpu_rvalid |
| cpu_addr | input | 32 | Word address of the request |
| cpu_stall | output | 1 | Request not served this cycle |
| cpu_rvalid | output | 1 | cpu_rdata carries the requested word |
| cpu_rdata | output | 32 | Returned data word |
| mem_req | output | 1 | Memory read outstanding |
| mem_addr | output | 32 | Word address of the memory read |
| mem_ready | input | 1 | Memory returns mem_rdata this cycle |
| mem_rdata | input | 32 | Data word from memory |

## Verification
The bench drives traffic into one set until it is full. It then re-touches an old line and forces an eviction.

A design that ignores hits when it updates recency would evict the line that was just touched. A design that evicts before the set is full would lose a line that should still hit. Each of these shows up as a wrong hit or miss on a later request.

The memory latency ranges from zero wait cycles to several, and ready pulses are sent while no read is outstanding. These catch a fill that writes stale data, an address that moves during the wait, and a spurious fill that corrupts a way. Traffic in one set is interleaved with traffic in another to expose recency or valid flags that leak between sets.

// File: rtl/lru_cache_pkg.sv
package lru_cache_pkg;

    localparam int NWAYS = 4;
    localparam int WAY_W = 2;

    typedef logic [WAY_W-1:0]   way_t;
    typedef logic [WAY_W-1:0]   age_t;
    typedef logic [NWAYS-1:0]   way_vec_t;
    typedef age_t [NWAYS-1:0]   age_row_t;

    typedef enum logic [0:0] {
        ST_LOOKUP = 1'b0,
        ST_FILL   = 1'b1
    } ctrl_state_e;

    typedef struct packed {
        logic en;
        way_t way;
    } touch_t;

    // distinct ages after reset: way w starts with age w
    function automatic age_row_t ages_reset();
        age_row_t r;
        for (int w = 0; w < NWAYS; w++) begin
            r[w] = age_t'(w);
        end
        return r;
    endfunction

    function automatic way_vec_t oldest_of(age_row_t a);
        way_vec_t v;
        for (int w = 0; w < NWAYS; w++) begin
            v[w] = (a[w] == age_t'(NWAYS - 1));
        end
        return v;
    endfunction

    // lowest-numbered invalid way, else the oldest way
    function automatic way_t pick_victim(way_vec_t valid, age_row_t a);
        way_t v     = '0;
        logic found = 1'b0;
        for (int w = 0; w < NWAYS; w++) begin
            if (!valid[w] && !found) begin
                v     = way_t'(w);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < NWAYS; w++) begin
                if (a[w] == age_t'(NWAYS - 1)) begin
                    v = way_t'(w);
                end
            end
        end
        return v;
    endfunction

    // touched way becomes youngest; ways younger than it age by one
    function automatic age_row_t age_touch(age_row_t a, way_t t);
        age_row_t r;
        age_t     prev = a[t];
        for (int w = 0; w < NWAYS; w++) begin
            if (way_t'(w) == t) begin
                r[w] = '0;
            end else if (a[w] < prev) begin
                r[w] = a[w] + age_t'(1);
            end else begin
                r[w] = a[w];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/lru_way_bank.sv
module lru_way_bank #(
    parameter int SET_W  = 8,
    parameter int TAG_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_mem [SETS];
    logic [DATA_W-1:0] dat_mem [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_set] <= wr_tag;
            dat_mem[wr_set] <= wr_data;
        end
    end

    assign rd_valid = vld_q[rd_set];
    assign rd_hit   = rd_valid && (tag_mem[rd_set] == rd_tag);
    assign rd_data  = dat_mem[rd_set];

endmodule

// File: rtl/lru_age_table.sv
module lru_age_table
    import lru_cache_pkg::*;
#(
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    input  way_vec_t         valid_row,
    output way_t             victim,
    output way_vec_t         oldest,
    input  touch_t           touch,
    input  logic [SET_W-1:0] touch_set
);
    localparam int SETS = 1 << SET_W;

    age_row_t ages_q [SETS];
    age_row_t rd_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                ages_q[s] <= ages_reset();
            end
        end else if (touch.en) begin
            ages_q[touch_set] <= age_touch(ages_q[touch_set], touch.way);
        end
    end

    assign rd_row = ages_q[rd_set];
    assign victim = pick_victim(valid_row, rd_row);
    assign oldest = oldest_of(rd_row);

endmodule

// File: rtl/lru_fill_ctrl.sv
module lru_fill_ctrl
    import lru_cache_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              any_hit,
    input  way_t              victim,
    input  logic              mem_ready,
    output logic              cpu_stall,
    output logic              cpu_rvalid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] pend_addr,
    output logic              fill_en,
    output way_t              fill_way
);
    ctrl_state_e       state_q;
    logic [ADDR_W-1:0] pend_addr_q;
    way_t              pend_way_q;
    logic              lookup_act;

    assign lookup_act = (state_q == ST_LOOKUP) && cpu_req;
    assign cpu_rvalid = lookup_act && any_hit;
    assign cpu_stall  = (lookup_act && !any_hit) || (state_q == ST_FILL);
    assign mem_req    = (state_q == ST_FILL);
    assign fill_en    = (state_q == ST_FILL) && mem_ready;
    assign pend_addr  = pend_addr_q;
    assign fill_way   = pend_way_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_LOOKUP;
            pend_addr_q <= '0;
            pend_way_q  <= '0;
        end else begin
            unique case (state_q)
                ST_LOOKUP: begin
                    if (lookup_act && !any_hit) begin
                        state_q     <= ST_FILL;
                        pend_addr_q <= cpu_addr;
                        pend_way_q  <= victim;
                    end
                end
                ST_FILL: begin
                    if (mem_ready) begin
                        state_q <= ST_LOOKUP;
                    end
                end
                default: state_q <= ST_LOOKUP;
            endcase
        end
    end

endmodule

// File: rtl/sa_lru_cache.sv
module sa_lru_cache
    import lru_cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SET_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_stall,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - SET_W;

    logic [SET_W-1:0]  rd_set;
    logic [TAG_W-1:0]  rd_tag;
    logic [SET_W-1:0]  fill_set;
    logic [TAG_W-1:0]  fill_tag;
    way_vec_t          hit_vec;
    way_vec_t          valid_row;
    way_vec_t          oldest_vec;
    logic [DATA_W-1:0] way_data [NWAYS];
    way_t              hit_way;
    way_t              victim;
    way_t              fill_way;
    logic              fill_en;
    logic              any_hit;
    touch_t            touch;
    logic [SET_W-1:0]  touch_set;

    assign rd_set   = cpu_addr[SET_W-1:0];
    assign rd_tag   = cpu_addr[ADDR_W-1:SET_W];
    assign fill_set = mem_addr[SET_W-1:0];
    assign fill_tag = mem_addr[ADDR_W-1:SET_W];

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        lru_way_bank #(
            .SET_W (SET_W),
            .TAG_W (TAG_W),
            .DATA_W(DATA_W)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .rd_set  (rd_set),
            .rd_tag  (rd_tag),
            .rd_valid(valid_row[w]),
            .rd_hit  (hit_vec[w]),
            .rd_data (way_data[w]),
            .wr_en   (fill_en && (fill_way == way_t'(w))),
            .wr_set  (fill_set),
            .wr_tag  (fill_tag),
            .wr_data (mem_rdata)
        );
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_way   = '0;
        cpu_rdata = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way = way_t'(w);
            end
            cpu_rdata = cpu_rdata | (way_data[w] & {DATA_W{hit_vec[w]}});
        end
    end

    always_comb begin
        touch.en  = cpu_rvalid || fill_en;
        touch.way = fill_en ? fill_way : hit_way;
        touch_set = fill_en ? fill_set : rd_set;
    end

    lru_age_table #(
        .SET_W(SET_W)
    ) u_ages (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (rd_set),
        .valid_row(valid_row),
        .victim   (victim),
        .oldest   (oldest_vec),
        .touch    (touch),
        .touch_set(touch_set)
    );

    lru_fill_ctrl #(
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .any_hit   (any_hit),
        .victim    (victim),
        .mem_ready (mem_ready),
        .cpu_stall (cpu_stall),
        .cpu_rvalid(cpu_rvalid),
        .mem_req   (mem_req),
        .pend_addr (mem_addr),
        .fill_en   (fill_en),
        .fill_way  (fill_way)
    );

endmodule

// File: rtl/lru_cache_checker.sv
module lru_cache_checker
    import lru_cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_stall,
    input logic              cpu_rvalid,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_rdata,
    input way_vec_t          hit_vec,
    input way_vec_t          oldest_vec
);
    assert_single_hit_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> $onehot0(hit_vec));

    assert_hit_no_mem_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |-> (!cpu_stall && !mem_req));

    assert_miss_issues_read_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_stall && !mem_req) |=> (mem_req && mem_addr == $past(cpu_addr)));

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    assert_fill_returns_word_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready) |=>
            (!(cpu_req && cpu_addr == $past(mem_addr)) ||
             (cpu_rvalid && cpu_rdata == $past(mem_rdata))));

    assert_single_oldest_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1);

endmodule

bind sa_lru_cache lru_cache_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .cpu_stall (cpu_stall),
    .cpu_rvalid(cpu_rvalid),
    .cpu_rdata (cpu_rdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .hit_vec   (hit_vec),
    .oldest_vec(oldest_vec)
);

// File: tb/sa_lru_cache_bench.sv
module sa_lru_cache_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req;
    logic [31:0] cpu_addr;
    logic        cpu_stall;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready;
    logic [31:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model: per-set recency list, index 0 = most recent
    int          m_order [256][4];
    bit          m_vld   [256][4];
    logic [23:0] m_tag   [256][4];
    bit          m_fill;
    logic [31:0] m_pend;
    int          m_wait;
    int          lat;
    logic [31:0] lfsr;

    always #4 clk = ~clk;

    sa_lru_cache u_sa_lru_cache (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .cpu_stall (cpu_stall),
        .cpu_rvalid(cpu_rvalid),
        .cpu_rdata (cpu_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [31:0] memval(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int model_find(logic [31:0] a);
        int s = int'(a[7:0]);
        for (int w = 0; w < 4; w++) begin
            if (m_vld[s][w] && m_tag[s][w] == a[31:8]) return w;
        end
        return -1;
    endfunction

    task automatic model_touch(input int s, input int w);
        int pos = 0;
        for (int i = 0; i < 4; i++) if (m_order[s][i] == w) pos = i;
        for (int i = pos; i > 0; i--) m_order[s][i] = m_order[s][i-1];
        m_order[s][0] = w;
    endtask

    task automatic model_install(input logic [31:0] a);
        int s = int'(a[7:0]);
        int v = -1;
        for (int w = 3; w >= 0; w--) if (!m_vld[s][w]) v = w;
        if (v < 0) v = m_order[s][3];
        m_vld[s][v] = 1'b1;
        m_tag[s][v] = a[31:8];
        model_touch(s, v);
    endtask

    // one clock: drive, compare against model, advance model
    task automatic tick(input bit req, input logic [31:0] a, input bit stray, output bit got);
        int hw;
        cpu_req  = req;
        cpu_addr = a;
        if (m_fill) begin
            mem_ready = (m_wait >= lat);
            mem_rdata = memval(m_pend);
        end else begin
            mem_ready = stray;
            mem_rdata = 32'hDEAD_BEEF;
        end
        #1;
        got = 1'b0;
        hw  = model_find(a);
        if (m_fill) begin
            chk(cpu_stall == 1'b1, "R11", "stall during fill", 32'(cpu_stall), 32'd1);
            chk(cpu_rvalid == 1'b0, "R11", "rvalid during fill", 32'(cpu_rvalid), 32'd0);
            chk(mem_req == 1'b1, "R4", "mem_req during fill", 32'(mem_req), 32'd1);
            chk(mem_addr == m_pend, "R11", "mem_addr", mem_addr, m_pend);
        end else begin
            chk(mem_req == 1'b0, "R12", "mem_req idle", 32'(mem_req), 32'd0);
            if (req && hw >= 0) begin
                chk(cpu_rvalid == 1'b1, "R3", "rvalid on hit", 32'(cpu_rvalid), 32'd1);
                chk(cpu_stall == 1'b0, "R3", "stall on hit", 32'(cpu_stall), 32'd0);
                chk(cpu_rdata == memval(a), "R5", "hit data", cpu_rdata, memval(a));
                got = 1'b1;
            end else if (req) begin
                chk(cpu_stall == 1'b1, "R4", "stall on miss", 32'(cpu_stall), 32'd1);
                chk(cpu_rvalid == 1'b0, "R4", "rvalid on miss", 32'(cpu_rvalid), 32'd0);
            end else begin
                chk(cpu_stall == 1'b0, "R1", "stall no req", 32'(cpu_stall), 32'd0);
                chk(cpu_rvalid == 1'b0, "R1", "rvalid no req", 32'(cpu_rvalid), 32'd0);
            end
        end
        @(posedge clk);
        if (m_fill) begin
            if (mem_ready) begin
                model_install(m_pend);
                m_fill = 1'b0;
            end else begin
                m_wait++;
            end
        end else if (req) begin
            if (hw >= 0) begin
                model_touch(int'(a[7:0]), hw);
            end else begin
                m_fill = 1'b1;
                m_pend = a;
                m_wait = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic access(input logic [31:0] a, output bit first_hit);
        bit got;
        tick(1'b1, a, 1'b0, got);
        first_hit = got;
        for (int n = 0; n < 64 && !got; n++) tick(1'b1, a, 1'b0, got);
    endtask

    task automatic expect_access(input logic [31:0] a, input bit exp_hit, input string req);
        bit h;
        access(a, h);
        chk(h == exp_hit, req, "hit/miss outcome", 32'(h), 32'(exp_hit));
    endtask

    task automatic idle(input int n, input bit stray);
        bit g;
        for (int i = 0; i < n; i++) tick(1'b0, 32'h0, stray, g);
    endtask

    initial begin
        for (int s = 0; s < 256; s++)
            for (int w = 0; w < 4; w++) begin
                m_order[s][w] = w;
                m_vld[s][w]   = 1'b0;
                m_tag[s][w]   = '0;
            end
        m_fill    = 1'b0;
        m_pend    = '0;
        m_wait    = 0;
        lat       = 2;
        lfsr      = 32'h1ACE_B00C;
        rst       = 1'b1;
        cpu_req   = 1'b0;
        cpu_addr  = '0;
        mem_ready = 1'b0;
        mem_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: quiet outputs and cold misses after reset
        idle(2, 1'b0);
        expect_access(32'h0000_0010, 1'b0, "R1");
        expect_access(32'h0000_0010, 1'b1, "R3");
        expect_access(32'h1234_5610, 1'b0, "R1");

        // R2 / R6: four tags in set 0x10 all retained
        expect_access(32'h0000_0110, 1'b0, "R2");
        expect_access(32'h0000_0210, 1'b0, "R2");
        expect_access(32'h0000_0011, 1'b0, "R2");
        expect_access(32'h0000_0010, 1'b1, "R6");
        expect_access(32'h0000_0110, 1'b1, "R6");
        expect_access(32'h0000_0210, 1'b1, "R6");
        expect_access(32'h1234_5610, 1'b1, "R6");

        // R8 / R7: refresh the oldest line, then evict
        expect_access(32'h0000_0010, 1'b1, "R8");
        expect_access(32'h0000_0410, 1'b0, "R7");
        expect_access(32'h0000_0010, 1'b1, "R8");
        expect_access(32'h0000_0210, 1'b1, "R7");
        expect_access(32'h1234_5610, 1'b1, "R7");
        expect_access(32'h0000_0410, 1'b1, "R7");
        expect_access(32'h0000_0110, 1'b0, "R7");

        // R9: fill set 0x20, churn set 0x10, set 0x20 untouched
        for (int i = 0; i < 4; i++) expect_access(32'(i * 256 + 32'h20), 1'b0, "R9");
        for (int i = 0; i < 12; i++) begin
            bit h;
            access(32'(i * 256 + 32'h10), h);
        end
        for (int i = 0; i < 4; i++) expect_access(32'(i * 256 + 32'h20), 1'b1, "R9");

        // R12: ready pulses with no outstanding read
        idle(4, 1'b1);
        expect_access(32'h0000_0020, 1'b1, "R12");
        expect_access(32'h0000_0030, 1'b0, "R12");

        // R5 / R11: memory latency of zero and of several cycles
        lat = 0;
        expect_access(32'h0000_0040, 1'b0, "R5");
        expect_access(32'h0000_0040, 1'b1, "R5");
        lat = 6;
        expect_access(32'h0000_0140, 1'b0, "R11");
        expect_access(32'h0000_0140, 1'b1, "R11");

        // mixed traffic over a few sets and tags, compared every cycle (R10)
        for (int i = 0; i < 400; i++) begin
            bit h;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lat  = int'(lfsr[10:9]);
            access({21'd0, lfsr[5:3], 6'd0, lfsr[1:0]}, h);
            if (lfsr[12]) idle(1, lfsr[13]);
        end
        expect_access(32'h0000_0040, 1'b1, "R10");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog: actual no completion expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule